// File: doc/BRIEF.md
# Speculative Load Address Table

This block lets a compiler hoist a load above stores that might write the same bytes. When a hoisted ("advanced") load issues, the block records the load's physical address, its access size and the destination register tag. Every store is compared against the recorded ranges, whether the core issues it or it is observed on the external bus. A store that touches any byte of a recorded range kills that entry. Later, a check instruction names the destination register. If the entry is still alive, the speculative value can be used. If not, the check reports either that the value must be reloaded or that control must branch to recovery code.

The table holds fewer slots than there are registers. Entries are found by register tag, not by address. When every slot is in use, a new advanced load displaces the least recently used entry. A use is a recording or a passing check. A check of a displaced, killed, cleared or flushed entry fails in the same way. The result of a check appears one cycle after the request.

Top module: `spec_ld_table`

## Requirements
- R1: After an advanced load is recorded, a check of its register tag passes (`res_pass_o`=1) until a store, flush, clear or replacement removes the entry.
- R2: A core store removes every entry whose byte range overlaps it, including a partial overlap. Ranges are naturally aligned and the size code maps to bytes as 0=1, 1=2, 2=4, 3=8. A store with no common byte leaves the entry alive.
- R3: A store observed on the external bus removes overlapping entries exactly as a core store does, and both ports may act in the same cycle.
- R4: A failed check raises `res_reload_o` when the check kind is 0 (reload) and `res_recover_o` when the kind is 1 (branch to recovery). With `res_valid_o` high, exactly one of pass, reload and recover is high. With it low, all three are low.
- R5: With every slot valid, recording a new tag displaces the least recently used entry, and a check of the displaced tag then fails.
- R6: Recording a tag that already has a live entry rewrites that entry in place. It takes no second slot and displaces nothing, and from then on only the new address range is snooped.
- R7: Flush removes every entry, so each following check fails until new loads are recorded. A check or an advanced load in the same cycle as a flush fails or is not recorded.
- R8: A store and a check in the same cycle apply the store first, so a check of an entry that the store overlaps fails.
- R9: A passing reload check with the clear flag set frees the entry, so a repeated check fails. The clear flag has no effect on branch-style checks or on failed checks.
- R10: A check result appears exactly one cycle after the request, and `res_valid_o` is high only in that cycle.
- R11: An advanced load that overlaps a store in the same cycle is not recorded, and any older entry for the same tag is dropped as well.
- R12: A passing check counts as a use for replacement, so a recently checked entry survives a displacement that takes an older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Remove all entries |
| ld_valid_i | input | 1 | Advanced load recorded this cycle |
| ld_tag_i | input | TAG_W | Destination register tag of the load |
| ld_addr_i | input | ADDR_W | Physical address of the load, naturally aligned |
| ld_size_i | input | 2 | Size code of the load (0=1, 1=2, 2=4, 3=8 bytes) |
| cst_valid_i | input | 1 | Core store present |
| cst_addr_i | input | ADDR_W | Core store address |
| cst_size_i | input | 2 | Core store size code |
| bst_valid_i | input | 1 | External bus store observed |
| bst_addr_i | input | ADDR_W | Bus store address |
| bst_size_i | input | 2 | Bus store size code |
| chk_valid_i | input | 1 | Check request |
| chk_tag_i | input | TAG_W | Register tag being checked |
| chk_kind_i | input | 1 | 0 = reload check, 1 = branch-to-recovery check |
| chk_clear_i | input | 1 | Free the entry after a passing reload check |
| res_valid_o | output | 1 | Check result valid (one cycle after request) |
| res_pass_o | output | 1 | Speculative value still valid |
| res_reload_o | output | 1 | Reload check failed, redo the load |
| res_recover_o | output | 1 | Branch check failed, enter recovery code |

## Verification
The assertions take it that every address is naturally aligned to its own size, because the overlap test compares only the bits above the larger access. They also take it that reset holds flush and all request inputs low. The stimulus builds each address by masking a small base down to the chosen size, so no misaligned access reaches the block. Addresses are kept inside a narrow window so that stores often overlap recorded loads. Tags are drawn from a range larger than the slot count so that replacement happens.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

  localparam int SZ_W = 2;

  typedef enum logic {
    CHK_RELOAD  = 1'b0,
    CHK_RECOVER = 1'b1
  } chk_kind_e;

  // Bytes covered by a size code.
  function automatic logic [3:0] size_bytes(input logic [SZ_W-1:0] code);
    return 4'(1 << code);
  endfunction

  // Naturally aligned ranges share a byte iff their addresses agree
  // above the span of the larger access.
  function automatic logic ranges_overlap(input logic [63:0] a, input logic [SZ_W-1:0] sa,
                                          input logic [63:0] b, input logic [SZ_W-1:0] sb);
    logic [SZ_W-1:0] big;
    logic [63:0]     low_mask;
    big      = (sa > sb) ? sa : sb;
    low_mask = 64'(size_bytes(big)) - 64'd1;
    return ((a ^ b) & ~low_mask) == 64'd0;
  endfunction

endpackage

// File: rtl/spec_ld_slot.sv
module spec_ld_slot
  import spec_ld_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic              drop,
  input  logic              st0_v,
  input  logic [ADDR_W-1:0] st0_addr,
  input  logic [SZ_W-1:0]   st0_size,
  input  logic              st1_v,
  input  logic [ADDR_W-1:0] st1_addr,
  input  logic [SZ_W-1:0]   st1_size,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              valid_o,
  output logic              kill_o,
  output logic              chk_hit_o,
  output logic              ld_hit_o
);

  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]   size_q;
  logic              hit0, hit1;

  assign hit0      = st0_v && ranges_overlap(64'(addr_q), size_q, 64'(st0_addr), st0_size);
  assign hit1      = st1_v && ranges_overlap(64'(addr_q), size_q, 64'(st1_addr), st1_size);
  assign kill_o    = valid_q && (hit0 || hit1);
  assign valid_o   = valid_q;
  assign chk_hit_o = valid_q && !kill_o && (tag_q == chk_tag);
  assign ld_hit_o  = valid_q && !kill_o && (tag_q == ld_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else begin
      if (flush)               valid_q <= 1'b0;
      else if (wr_en)          valid_q <= 1'b1;
      else if (kill_o || drop) valid_q <= 1'b0;
      if (wr_en && !flush) begin
        tag_q  <= wr_tag;
        addr_q <= wr_addr;
        size_q <= wr_size;
      end
    end
  end

endmodule

// File: rtl/spec_ld_lru.sv
module spec_ld_lru #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] touch_a,
  input  logic [N-1:0] touch_b,
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] victim_o
);

  localparam int RW = (N > 1) ? $clog2(N) : 1;
  typedef logic [N-1:0][RW-1:0] rank_vec_t;

  rank_vec_t rank_q, rank_mid, rank_d;

  // Move the selected slot to rank 0; slots that were more recent age by one.
  function automatic rank_vec_t touch(input rank_vec_t r, input logic [N-1:0] sel);
    rank_vec_t       o;
    logic [RW-1:0]   sel_rank;
    sel_rank = '0;
    for (int i = 0; i < N; i++) if (sel[i]) sel_rank |= r[i];
    o = r;
    if (|sel) begin
      for (int i = 0; i < N; i++) begin
        if (sel[i])               o[i] = '0;
        else if (r[i] < sel_rank) o[i] = r[i] + RW'(1);
      end
    end
    return o;
  endfunction

  assign rank_mid = touch(rank_q, touch_a);
  assign rank_d   = touch(rank_mid, touch_b);

  always_comb begin
    victim_o = '0;
    if (|free_vec) begin
      for (int i = N - 1; i >= 0; i--) if (free_vec[i]) victim_o = N'(1) << i;
    end else begin
      for (int i = 0; i < N; i++) if (rank_mid[i] == RW'(N - 1)) victim_o[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= RW'(i);
    end else begin
      rank_q <= rank_d;
    end
  end

endmodule

// File: rtl/spec_ld_result.sv
module spec_ld_result
  import spec_ld_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  chk_kind_e kind,
  input  logic      hit,
  output logic      res_valid_o,
  output logic      res_pass_o,
  output logic      res_reload_o,
  output logic      res_recover_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o   <= 1'b0;
      res_pass_o    <= 1'b0;
      res_reload_o  <= 1'b0;
      res_recover_o <= 1'b0;
    end else begin
      res_valid_o   <= req;
      res_pass_o    <= req && hit;
      res_reload_o  <= req && !hit && (kind == CHK_RELOAD);
      res_recover_o <= req && !hit && (kind == CHK_RECOVER);
    end
  end

endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
  import spec_ld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              ld_valid_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [1:0]        ld_size_i,
  input  logic              cst_valid_i,
  input  logic [ADDR_W-1:0] cst_addr_i,
  input  logic [1:0]        cst_size_i,
  input  logic              bst_valid_i,
  input  logic [ADDR_W-1:0] bst_addr_i,
  input  logic [1:0]        bst_size_i,
  input  logic              chk_valid_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  input  logic              chk_kind_i,
  input  logic              chk_clear_i,
  output logic              res_valid_o,
  output logic              res_pass_o,
  output logic              res_reload_o,
  output logic              res_recover_o
);

  localparam int N = ENTRIES;

  // Named internal events, also observed by the bound checker.
  logic [N-1:0] slot_valid;
  logic [N-1:0] slot_kill;
  logic [N-1:0] slot_chk_hit;
  logic [N-1:0] slot_ld_hit;
  logic [N-1:0] chk_hit_eff;
  logic [N-1:0] clr_vec;
  logic [N-1:0] free_vec;
  logic [N-1:0] victim_vec;
  logic [N-1:0] wr_vec;
  logic [N-1:0] touch_chk;
  logic         ld_killed;
  logic         ld_record;
  logic         ld_drop;
  logic         chk_any_hit;
  logic         chk_clears;
  chk_kind_e    kind;

  assign kind = chk_kind_e'(chk_kind_i);

  // A load colliding with a same-cycle store is not recorded.
  assign ld_killed = (cst_valid_i && ranges_overlap(64'(ld_addr_i), ld_size_i, 64'(cst_addr_i), cst_size_i))
                  || (bst_valid_i && ranges_overlap(64'(ld_addr_i), ld_size_i, 64'(bst_addr_i), bst_size_i));
  assign ld_record = ld_valid_i && !flush_i && !ld_killed;
  assign ld_drop   = ld_valid_i && !flush_i && ld_killed;

  // Stores act before the check: slot hits already exclude killed slots.
  assign chk_hit_eff = (chk_valid_i && !flush_i) ? slot_chk_hit : '0;
  assign chk_any_hit = |chk_hit_eff;
  assign chk_clears  = chk_clear_i && (kind == CHK_RELOAD);
  assign touch_chk   = chk_hit_eff;

  assign clr_vec  = (chk_clears ? chk_hit_eff : '0) | (ld_drop ? slot_ld_hit : '0);
  assign free_vec = ~slot_valid | slot_kill | clr_vec;
  assign wr_vec   = ld_record ? ((|slot_ld_hit) ? slot_ld_hit : victim_vec) : '0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    spec_ld_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_i),
      .wr_en    (wr_vec[g]),
      .wr_tag   (ld_tag_i),
      .wr_addr  (ld_addr_i),
      .wr_size  (ld_size_i),
      .drop     (clr_vec[g]),
      .st0_v    (cst_valid_i),
      .st0_addr (cst_addr_i),
      .st0_size (cst_size_i),
      .st1_v    (bst_valid_i),
      .st1_addr (bst_addr_i),
      .st1_size (bst_size_i),
      .chk_tag  (chk_tag_i),
      .ld_tag   (ld_tag_i),
      .valid_o  (slot_valid[g]),
      .kill_o   (slot_kill[g]),
      .chk_hit_o(slot_chk_hit[g]),
      .ld_hit_o (slot_ld_hit[g])
    );
  end

  spec_ld_lru #(.N(N)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .touch_a (touch_chk),
    .touch_b (wr_vec),
    .free_vec(free_vec),
    .victim_o(victim_vec)
  );

  spec_ld_result u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (chk_valid_i),
    .kind         (kind),
    .hit          (chk_any_hit),
    .res_valid_o  (res_valid_o),
    .res_pass_o   (res_pass_o),
    .res_reload_o (res_reload_o),
    .res_recover_o(res_recover_o)
  );

endmodule

// File: rtl/spec_ld_checker.sv
module spec_ld_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush_i,
  input logic         chk_valid_i,
  input logic         res_valid_o,
  input logic         res_pass_o,
  input logic         res_reload_o,
  input logic         res_recover_o,
  input logic [N-1:0] slot_valid,
  input logic [N-1:0] slot_kill,
  input logic [N-1:0] slot_chk_hit,
  input logic [N-1:0] wr_vec
);

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o == $past(chk_valid_i)); // R10

  AST_RES_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $onehot({res_pass_o, res_reload_o, res_recover_o})); // R4

  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> !(res_pass_o || res_reload_o || res_recover_o)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> slot_valid == '0); // R7

  AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_kill & ~wr_vec) != '0) |=> ((slot_valid & $past(slot_kill & ~wr_vec)) == '0)); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec != '0 && !flush_i) |=> ((slot_valid & $past(wr_vec)) == $past(wr_vec))); // R1

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_chk_hit)); // R6

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R6

endmodule

bind spec_ld_table spec_ld_checker #(.N(ENTRIES)) u_spec_ld_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .chk_valid_i  (chk_valid_i),
  .res_valid_o  (res_valid_o),
  .res_pass_o   (res_pass_o),
  .res_reload_o (res_reload_o),
  .res_recover_o(res_recover_o),
  .slot_valid   (slot_valid),
  .slot_kill    (slot_kill),
  .slot_chk_hit (slot_chk_hit),
  .wr_vec       (wr_vec)
);

// File: tb/test_spec_ld_table.sv
module test_spec_ld_table;

  localparam int N = 16;
  localparam int TW = 7;
  localparam int AW = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, ldv = 0, cv = 0, bv = 0, chv = 0, chk_kind = 0, chk_clr = 0;
  logic [TW-1:0] ldtag = '0, chtag = '0;
  logic [AW-1:0] ldaddr = '0, caddr = '0, baddr = '0;
  logic [1:0] ldsz = '0, csz = '0, bsz = '0;
  logic rv, rp, rr, rc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spec_ld_table #(.ENTRIES(N), .TAG_W(TW), .ADDR_W(AW)) i_spec_ld_table (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .ld_valid_i(ldv), .ld_tag_i(ldtag), .ld_addr_i(ldaddr), .ld_size_i(ldsz),
    .cst_valid_i(cv), .cst_addr_i(caddr), .cst_size_i(csz),
    .bst_valid_i(bv), .bst_addr_i(baddr), .bst_size_i(bsz),
    .chk_valid_i(chv), .chk_tag_i(chtag), .chk_kind_i(chk_kind), .chk_clear_i(chk_clr),
    .res_valid_o(rv), .res_pass_o(rp), .res_reload_o(rr), .res_recover_o(rc));

  // Reference model: live entries in recency order, most recent first.
  typedef struct { int tag; longint unsigned addr; int sz; } ent_t;
  ent_t model[$];

  function automatic bit bytes_meet(longint unsigned a, int sa, longint unsigned b, int sb);
    longint unsigned na = longint'(1) << sa;
    longint unsigned nb = longint'(1) << sb;
    return (a < b + nb) && (b < a + na);
  endfunction

  function automatic int find_tag(int t);
    foreach (model[i]) if (model[i].tag == t) return i;
    return -1;
  endfunction

  // Apply one clock of the requirements to the model; return expected outputs.
  function automatic logic [3:0] model_step();
    logic [3:0] e = 4'b0000; // {valid, pass, reload, recover}
    bit hit = 0;
    if (flush) begin
      model.delete();
      if (chv) e = chk_kind ? 4'b1001 : 4'b1010;
      return e;
    end
    for (int i = model.size() - 1; i >= 0; i--)
      if ((cv && bytes_meet(model[i].addr, model[i].sz, caddr, csz)) ||
          (bv && bytes_meet(model[i].addr, model[i].sz, baddr, bsz)))
        model.delete(i);
    if (chv) begin
      int k = find_tag(chtag);
      hit = (k >= 0);
      if (hit) begin
        ent_t x = model[k];
        model.delete(k);
        if (!(chk_kind == 0 && chk_clr)) model.push_front(x);
        e = 4'b1100;
      end else e = chk_kind ? 4'b1001 : 4'b1010;
    end
    if (ldv) begin
      bit col = (cv && bytes_meet(ldaddr, ldsz, caddr, csz)) || (bv && bytes_meet(ldaddr, ldsz, baddr, bsz));
      int k = find_tag(ldtag);
      if (k >= 0) model.delete(k);
      if (!col) begin
        ent_t x;
        x.tag = ldtag; x.addr = ldaddr; x.sz = ldsz;
        if (model.size() == N) void'(model.pop_back());
        model.push_front(x);
      end
    end
    return e;
  endfunction

  task automatic idle_in();
    flush = 0; ldv = 0; cv = 0; bv = 0; chv = 0; chk_kind = 0; chk_clr = 0;
  endtask

  // One clock: inputs set at negedge, result compared at the next negedge.
  task automatic tick(string req);
    logic [3:0] exp_q, act;
    exp_q = model_step();
    @(posedge clk);
    @(negedge clk);
    act = {rv, rp, rr, rc};
    checks++;
    if (act !== exp_q) begin
      errors++;
      $display("FAIL %s: {valid,pass,reload,recover} actual %b expected %b", req, act, exp_q);
    end
    idle_in();
  endtask

  task automatic do_load(int t, longint unsigned a, int s);
    ldv = 1; ldtag = TW'(t); ldaddr = AW'(a); ldsz = 2'(s);
  endtask
  task automatic do_check(int t, bit kind, bit clr);
    chv = 1; chtag = TW'(t); chk_kind = kind; chk_clr = clr;
  endtask
  task automatic do_cst(longint unsigned a, int s);
    cv = 1; caddr = AW'(a); csz = 2'(s);
  endtask
  task automatic do_bst(longint unsigned a, int s);
    bv = 1; baddr = AW'(a); bsz = 2'(s);
  endtask

  // Directed check whose expected outcome is also stated literally.
  task automatic expect_chk(string req, int t, bit kind, bit clr, logic [3:0] lit);
    logic [3:0] exp_q;
    do_check(t, kind, clr);
    exp_q = model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({rv, rp, rr, rc} !== lit || exp_q !== lit) begin
      errors++;
      $display("FAIL %s: tag %0d actual %b expected %b", req, t, {rv, rp, rr, rc}, lit);
    end
    idle_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    @(negedge clk);
    checks++;
    if ({rv, rp, rr, rc} !== 4'b0000) begin
      errors++;
      $display("FAIL R10: reset outputs actual %b expected 0000", {rv, rp, rr, rc});
    end
    expect_chk("R7", 5, 0, 0, 4'b1010);  // empty after reset: reload check fails
    // R1: record then check
    do_load(5, 'h1000, 3); tick("R1");
    expect_chk("R1", 5, 0, 0, 4'b1100);
    // R2: non-overlapping core store keeps, partial overlap kills
    do_cst('h1008, 2); tick("R2");
    expect_chk("R2", 5, 1, 0, 4'b1100);
    do_cst('h1006, 1); tick("R2");
    expect_chk("R2", 5, 1, 0, 4'b1001);  // R4 recover flavour
    // R3: bus store
    do_load(6, 'h2004, 2); tick("R1");
    do_bst('h2007, 0); tick("R3");
    expect_chk("R3", 6, 0, 0, 4'b1010);
    // R8: store and check same cycle
    do_load(7, 'h3000, 1); tick("R1");
    do_cst('h3001, 0); do_check(7, 0, 0);
    begin : same_cycle
      logic [3:0] e;
      e = model_step();
      @(posedge clk); @(negedge clk);
      checks++;
      if ({rv, rp, rr, rc} !== 4'b1010 || e !== 4'b1010) begin
        errors++;
        $display("FAIL R8: actual %b expected 1010", {rv, rp, rr, rc});
      end
      idle_in();
    end
    // R9: clear flag
    do_load(8, 'h4000, 0); tick("R1");
    expect_chk("R9", 8, 1, 1, 4'b1100);  // ignored on branch flavour
    expect_chk("R9", 8, 0, 1, 4'b1100);
    expect_chk("R9", 8, 0, 0, 4'b1010);
    // R6: overwrite same tag, old range no longer snooped
    do_load(9, 'h5000, 3); tick("R6");
    do_load(9, 'h6000, 3); tick("R6");
    do_cst('h5000, 3); tick("R6");
    expect_chk("R6", 9, 0, 0, 4'b1100);
    // R11: load colliding with same-cycle store drops old entry too
    do_load(9, 'h7000, 2); do_bst('h7002, 1); tick("R11");
    expect_chk("R11", 9, 0, 0, 4'b1010);
    // R7: flush
    do_load(10, 'h8000, 0); tick("R1");
    flush = 1; do_load(11, 'h9000, 0); tick("R7");
    expect_chk("R7", 10, 0, 0, 4'b1010);
    expect_chk("R7", 11, 1, 0, 4'b1001);
    // R5 / R12: fill, refresh tag 0, displace
    for (int t = 0; t < N; t++) begin
      do_load(t, 'h10000 + 64 * t, 3); tick("R5");
    end
    expect_chk("R12", 0, 0, 0, 4'b1100);
    do_load(40, 'h20000, 3); tick("R5");
    expect_chk("R5", 1, 0, 0, 4'b1010);
    expect_chk("R12", 0, 0, 0, 4'b1100);
    expect_chk("R5", 2, 0, 0, 4'b1100);
    // Mixed traffic compared against the model every clock
    for (int c = 0; c < 4000; c++) begin
      int s;
      if ($urandom_range(0, 199) == 0) flush = 1;
      if ($urandom_range(0, 1) == 1) begin
        s = $urandom_range(0, 3);
        do_load($urandom_range(0, 23), ($urandom_range(0, 127) + 'h1000) & ~((1 << s) - 1), s);
      end
      if ($urandom_range(0, 4) == 0) begin
        s = $urandom_range(0, 3);
        do_cst(($urandom_range(0, 127) + 'h1000) & ~((1 << s) - 1), s);
      end
      if ($urandom_range(0, 5) == 0) begin
        s = $urandom_range(0, 3);
        do_bst(($urandom_range(0, 127) + 'h1000) & ~((1 << s) - 1), s);
      end
      if ($urandom_range(0, 1) == 1)
        do_check($urandom_range(0, 23), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      tick("R2 R3 R4 R5 R6 R8 R9 R11 R12 mixed");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule